// File: doc/BRIEF.md
# Hold-to-Kill Power Button Timer

This block sits beside a platform power controller and turns the user's physical controls into two requests. A press of the already-debounced power button, or opening the lid, while the controller reports that the platform is off, produces a single-cycle power-on request. A press also starts a hold timer that counts a slow tick input (one tick per millisecond in the intended use). If the button is still held when the timer reaches its limit, a sticky force-shutdown flag is raised. Letting go of the button before that point abandons the countdown.

The flag can also be raised at once by an immediate-kill input. It then stays raised until the power controller pulses a clear input as it starts its next power-up. When the immediate-kill input or an expiring hold lands in the same cycle as the clear, setting wins. The hold limit is a parameter, 8000 ticks by default. A second parameter decides whether the lid is a wake source.

Top module: `hold_kill_ctl`

## Requirements
- R1: After reset, `pwr_on_o` and `kill_flag_o` are both 0.
- R2: A cycle in which `btn_i` is 1 after being 0 in the previous cycle, with `all_off_i` = 1, makes `pwr_on_o` equal to 1 for exactly the next cycle.
- R3: With the lid wake option on (the default), a cycle in which `lid_i` is 1 after being 0, with `all_off_i` = 1, makes `pwr_on_o` equal to 1 for exactly the next cycle. A button edge and a lid edge in the same cycle give one single pulse.
- R4: Rising edges seen while `all_off_i` = 0 give no pulse. A level that is held high gives no further pulse.
- R5: The press cycle itself is not counted, even if `tick_i` is 1 in it. Counting starts after that cycle. If `btn_i` stays 1, `kill_flag_o` becomes 1 after the edge that samples the HOLD_TICKS-th cycle with `tick_i` = 1.
- R6: If `btn_i` returns to 0 before the limit is reached, the countdown is dropped: later ticks do not raise the flag, and a new press counts again from zero.
- R7: `kill_now_i` = 1 in a cycle makes `kill_flag_o` equal to 1 from the next cycle on.
- R8: Once set, `kill_flag_o` stays 1 until a cycle with `kill_clr_i` = 1. After that edge it is 0.
- R9: If a set (R5 or R7) and `kill_clr_i` fall in the same cycle, `kill_flag_o` is 1 after that edge.
- R10: After the countdown has expired, keeping the button held does not raise the flag again once it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timebase tick for the hold countdown |
| btn_i | input | 1 | Debounced power-button level, 1 = pressed |
| lid_i | input | 1 | Lid level, 1 = open |
| all_off_i | input | 1 | Platform reported as being in an off state |
| kill_now_i | input | 1 | Immediate force-shutdown request |
| kill_clr_i | input | 1 | Clear pulse issued at the start of power-up |
| pwr_on_o | output | 1 | Single-cycle power-on request |
| kill_flag_o | output | 1 | Sticky force-shutdown flag |

## Verification
The flag register has three drivers: the expiring hold countdown, the immediate-kill input and the clear pulse. Two of them can land in the same cycle. The bench drives `kill_now_i` and `kill_clr_i` together in one cycle and expects the flag to be high afterwards. It also clears the flag while the button is still held after an expiry, and expects the flag to stay low. A button edge and a lid edge in the same cycle are judged on the wake side: they must give a single one-cycle request.

// File: rtl/hkt_pkg.sv
package hkt_pkg;

   typedef enum logic {
      HT_IDLE = 1'b0,
      HT_RUN  = 1'b1
   } hold_state_t;

   // Counter width able to hold the values 0 .. n-1
   function automatic int cnt_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/hkt_edge.sv
module hkt_edge #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o
);

   logic [W-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_i;
   end

   for (genvar g = 0; g < W; g++) begin : g_bit
      assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
   end

endmodule

// File: rtl/hkt_hold_timer.sv
module hkt_hold_timer
   import hkt_pkg::*;
#(
   parameter int HOLD_TICKS = 8000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic hold_i,
   input  logic tick_i,
   output logic done_o
);

   localparam int CW = cnt_bits(HOLD_TICKS);
   localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

   hold_state_t   st_q;
   logic [CW-1:0] cnt_q;
   logic          at_last;

   assign at_last = (cnt_q == LAST);
   assign done_o  = (st_q == HT_RUN) && !start_i && hold_i && tick_i && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= HT_IDLE;
         cnt_q <= '0;
      end else if (start_i) begin
         st_q  <= HT_RUN;
         cnt_q <= '0;
      end else if (st_q == HT_RUN) begin
         if (!hold_i) begin
            st_q  <= HT_IDLE;
            cnt_q <= '0;
         end else if (tick_i) begin
            if (at_last) begin
               st_q  <= HT_IDLE;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/hkt_kill_flag.sv
module hkt_kill_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

endmodule

// File: rtl/hold_kill_ctl.sv
module hold_kill_ctl #(
   parameter int HOLD_TICKS  = 8000,
   parameter bit LID_WAKE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic btn_i,
   input  logic lid_i,
   input  logic all_off_i,
   input  logic kill_now_i,
   input  logic kill_clr_i,
   output logic pwr_on_o,
   output logic kill_flag_o
);

   localparam int NSRC = 2;
   localparam int BTN  = 0;
   localparam int LID  = 1;

   if (HOLD_TICKS < 2) begin : g_bad_hold
      $error("HOLD_TICKS must be at least 2");
   end

   logic [NSRC-1:0] lvl;
   logic [NSRC-1:0] rise;
   logic [NSRC-1:0] wake_mask;
   logic            hold_done;
   logic            pwr_q;

   assign lvl[BTN] = btn_i;
   assign lvl[LID] = lid_i;

   hkt_edge #(.W(NSRC)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl),
      .rise_o (rise)
   );

   assign wake_mask[BTN] = 1'b1;
   if (LID_WAKE_EN) begin : g_lid_wake
      assign wake_mask[LID] = 1'b1;
   end else begin : g_no_lid_wake
      assign wake_mask[LID] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pwr_q <= 1'b0;
      else        pwr_q <= all_off_i && |(rise & wake_mask);
   end
   assign pwr_on_o = pwr_q;

   hkt_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (rise[BTN]),
      .hold_i  (btn_i),
      .tick_i  (tick_i),
      .done_o  (hold_done)
   );

   hkt_kill_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (kill_now_i | hold_done),
      .clr_i  (kill_clr_i),
      .flag_o (kill_flag_o)
   );

endmodule

module hold_kill_ctl_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_i,
   input logic btn_i,
   input logic all_off_i,
   input logic kill_now_i,
   input logic kill_clr_i,
   input logic done_i,
   input logic pwr_on_o,
   input logic kill_flag_o
);

   // R2
   wake_needs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_on_o |-> $past(all_off_i));

   // R7
   kill_now_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_now_i |=> kill_flag_o);

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_flag_o && !kill_clr_i) |=> kill_flag_o);

   // R8
   flag_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_clr_i && !kill_now_i && !done_i) |=> !kill_flag_o);

   // R9
   set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_clr_i && done_i) |=> kill_flag_o);

   // R5
   flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(kill_flag_o) |-> ($past(kill_now_i) || $past(done_i)));

   // R6
   expiry_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |-> (btn_i && tick_i));

endmodule

bind hold_kill_ctl hold_kill_ctl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .btn_i       (btn_i),
   .all_off_i   (all_off_i),
   .kill_now_i  (kill_now_i),
   .kill_clr_i  (kill_clr_i),
   .done_i      (hold_done),
   .pwr_on_o    (pwr_on_o),
   .kill_flag_o (kill_flag_o)
);

// File: tb/sim_hold_kill_ctl.sv
module sim_hold_kill_ctl;

   localparam int HOLD = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 1'b0, btn_i = 1'b0, lid_i = 1'b0, all_off_i = 1'b0;
   logic kill_now_i = 1'b0, kill_clr_i = 1'b0;
   logic pwr_on_o, kill_flag_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic  p;
      logic  f;
      string tag;
   } exp_t;

   exp_t q[$];

   always #2 clk = ~clk;

   hold_kill_ctl #(.HOLD_TICKS(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .btn_i(btn_i), .lid_i(lid_i),
      .all_off_i(all_off_i), .kill_now_i(kill_now_i), .kill_clr_i(kill_clr_i),
      .pwr_on_o(pwr_on_o), .kill_flag_o(kill_flag_o)
   );

   // monitor: compare outputs shortly after each edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (pwr_on_o !== e.p || kill_flag_o !== e.f) begin
            bad++;
            $display("FAIL %s: pwr_on=%b kill_flag=%b expected pwr_on=%b kill_flag=%b",
                     e.tag, pwr_on_o, kill_flag_o, e.p, e.f);
         end
      end
   end

   // driver: inputs for one cycle plus the outputs expected after that edge
   task automatic step(input logic b, input logic l, input logic off, input logic t,
                       input logic kn, input logic kc, input logic ep, input logic ef,
                       input string tag);
      exp_t e;
      @(negedge clk);
      btn_i = b; lid_i = l; all_off_i = off; tick_i = t;
      kill_now_i = kn; kill_clr_i = kc;
      e.p = ep; e.f = ef; e.tag = tag;
      q.push_back(e);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1
      step(0,0,0,0,0,0, 0,0, "R1");
      // R2 press while off
      step(1,0,1,0,0,0, 1,0, "R2");
      // R4 held level gives no second pulse
      step(1,0,1,0,0,0, 0,0, "R4");
      // R5 countdown
      for (int i = 0; i < HOLD-1; i++) step(1,0,0,1,0,0, 0,0, "R5");
      step(1,0,0,1,0,0, 0,1, "R5");
      step(1,0,0,1,0,0, 0,1, "R8");
      // R10 clear while still held, no retrigger
      step(1,0,0,1,0,1, 0,0, "R10");
      for (int i = 0; i < HOLD+1; i++) step(1,0,0,1,0,0, 0,0, "R10");
      step(0,0,0,0,0,0, 0,0, "R6");
      // R4 press while on, R6 release cancels
      step(1,0,0,0,0,0, 0,0, "R4");
      for (int i = 0; i < HOLD-2; i++) step(1,0,0,1,0,0, 0,0, "R6");
      step(0,0,0,1,0,0, 0,0, "R6");
      for (int i = 0; i < HOLD+1; i++) step(0,0,0,1,0,0, 0,0, "R6");
      // R6 re-press counts from zero; R5 tick in press cycle ignored
      step(1,0,0,1,0,0, 0,0, "R5");
      for (int i = 0; i < HOLD-1; i++) step(1,0,0,1,0,0, 0,0, "R6");
      step(1,0,0,1,0,0, 0,1, "R6");
      step(0,0,0,0,0,1, 0,0, "R8");
      // R7 immediate kill, R8 sticky, R9 collision
      step(0,0,0,0,1,0, 0,1, "R7");
      step(0,0,0,1,0,0, 0,1, "R8");
      step(0,0,0,0,1,1, 0,1, "R9");
      step(0,0,0,0,0,1, 0,0, "R8");
      // R3 lid wake
      step(0,1,1,0,0,0, 1,0, "R3");
      step(0,1,1,0,0,0, 0,0, "R3");
      step(0,0,1,0,0,0, 0,0, "R3");
      // R4 lid edge while on
      step(0,1,0,0,0,0, 0,0, "R4");
      step(0,0,1,0,0,0, 0,0, "R4");
      // R3 simultaneous button and lid edges
      step(1,1,1,0,0,0, 1,0, "R3");
      step(1,1,1,0,0,0, 0,0, "R3");
      step(0,0,0,0,0,0, 0,0, "R3");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule